// File: doc/BRIEF.md
# B-Channel Four-Frame Longword Packer

This block sits on a time-division-multiplexed serial line. It runs on the line's data clock and sees one bit per clock. A frame-sync pulse marks the first bit of every frame. Each frame carries two 8-bit bearer channels followed by two signalling bits. For each bearer channel, the block gathers the bytes of four consecutive frames into a 32-bit receive word. In the other direction, it serialises a 32-bit transmit word onto the line with the same layout. It also hands over the two signalling bits of each frame and sends two signalling bits of its own.

Each bearer channel has its own mode input. The mode selects how bits are ordered inside a byte: raw data travels msb first, and HDLC-encoded data travels lsb first. The byte order across the four frames never changes: the earliest frame always takes the top byte. The modes are latched at each four-frame boundary, so no word mixes the two bit orders. Transmit words are offered through a one-word pending slot. If that slot is empty at a boundary, the last word goes out again and an underrun flag is raised.

Top module: `bch_lw_packer`

## Requirements
- R1: In the cycle where `fsync` is high, the line bit is slot 0 of a new frame. Slots 0..7 belong to channel 1, slots 8..15 to channel 2, and slots 16..17 to the signalling pair. All later slots are idle.
- R2: With a channel's mode at 0 (raw), its byte is sent and received msb first: slot 0 (or 8) carries bit 7 of the byte.
- R3: With a channel's mode at 1 (HDLC), its byte is sent and received lsb first: the first slot of the channel carries bit 0 and the last slot carries bit 7.
- R4: The first frame after a boundary occupies bits 31:24 of the longword and the fourth frame occupies bits 7:0, in both modes and for both channels.
- R5: `rx_valid` is high for exactly one cycle, the cycle after the last channel-2 bit of the fourth frame. In that cycle `b1_rx_word` and `b2_rx_word` show the complete words, and they do not change until the next `rx_valid`.
- R6: The signalling bit in slot 16 goes to `d_rx[0]` and the bit in slot 17 goes to `d_rx[1]`. Both appear, with a one-cycle `d_valid`, in the cycle after slot 17. On transmit, `d_tx[0]` drives slot 16 and `d_tx[1]` drives slot 17.
- R7: The transmit words use the same bit order as receive (R2, R3) and the same byte order as receive (R4).
- R8: A word presented with `tx_load` is held as pending. It goes out only from the next frame 0 onward and never changes a four-frame group that is already in progress.
- R9: At each frame-0 boundary, if no word is pending, the previous words are sent again and `tx_underrun` goes to 1. A boundary that does find a pending word clears `tx_underrun`. The flag changes only at boundaries.
- R10: `tx_bit` is 1 in idle slots and at all times before the first `fsync` after reset.
- R11: The mode inputs are sampled only in a frame-0 `fsync` cycle. A change in mid-group has no effect until the next group.
- R12: A synchronous active-high `rst` clears the frame counter, the shift registers, the receive words, `rx_valid`, `d_valid` and `tx_underrun`. The first `fsync` after reset starts frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line data clock, one bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame sync, high during slot 0 |
| rx_bit | input | 1 | Received line bit |
| tx_bit | output | 1 | Transmitted line bit |
| mode_b1_hdlc | input | 1 | Channel 1 bit order: 0 raw msb first, 1 HDLC lsb first |
| mode_b2_hdlc | input | 1 | Channel 2 bit order |
| b1_rx_word | output | 32 | Last complete channel 1 receive word |
| b2_rx_word | output | 32 | Last complete channel 2 receive word |
| rx_valid | output | 1 | One-cycle strobe for a new receive word pair |
| d_rx | output | 2 | Signalling bits of the last frame |
| d_valid | output | 1 | One-cycle strobe for new `d_rx` |
| d_tx | input | 2 | Signalling bits to send in every frame |
| tx_load | input | 1 | Write `b1_tx_word`/`b2_tx_word` into the pending slot |
| b1_tx_word | input | 32 | Channel 1 transmit word |
| b2_tx_word | input | 32 | Channel 2 transmit word |
| tx_underrun | output | 1 | Previous word being resent |

## Verification
`tx_bit` is combinational from the current slot, so the bench compares it with its model 1 ns after each drive edge, in the same cycle. The receive words and `rx_valid` come due one cycle after slot 15 of the fourth frame. `d_rx` comes due one cycle after slot 17, and `tx_underrun` one cycle after the frame-0 `fsync`. Each of these is sampled at the falling edge that follows the rising edge where it registers, before the next stimulus is driven.

// File: rtl/bch_lw_packer.sv
module bch_lw_packer #(
  parameter int FRAME_BITS = 32,
  parameter int FRAMES     = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fsync,
  input  logic                  rx_bit,
  output logic                  tx_bit,
  input  logic                  mode_b1_hdlc,
  input  logic                  mode_b2_hdlc,
  output logic [8*FRAMES-1:0]   b1_rx_word,
  output logic [8*FRAMES-1:0]   b2_rx_word,
  output logic                  rx_valid,
  output logic [1:0]            d_rx,
  output logic                  d_valid,
  input  logic [1:0]            d_tx,
  input  logic                  tx_load,
  input  logic [8*FRAMES-1:0]   b1_tx_word,
  input  logic [8*FRAMES-1:0]   b2_tx_word,
  output logic                  tx_underrun
);
  localparam int W  = 8 * FRAMES;
  localparam int SW = $clog2(FRAME_BITS);
  localparam int FW = $clog2(FRAMES);

  logic          started, pend_full, d_first;
  logic [SW-1:0] slot_q;
  logic [FW-1:0] frm_q;
  logic [1:0]    mode_q;
  logic [W-1:0]  sh1, sh2, sh1_n, sh2_n;
  logic [W-1:0]  act1, act2, pend1, pend2;

  wire [SW-1:0] slot = fsync ? '0 : (slot_q == SW'(FRAME_BITS - 1) ? slot_q : slot_q + 1'b1);
  wire [FW-1:0] frm  = !fsync ? frm_q :
                       (!started || frm_q == FW'(FRAMES - 1)) ? '0 : frm_q + 1'b1;
  wire          live  = started | fsync;
  wire          bound = fsync && frm == '0;
  wire [1:0]    mode  = bound ? {mode_b2_hdlc, mode_b1_hdlc} : mode_q;

  wire in_b1 = live && slot < SW'(8);
  wire in_b2 = live && slot >= SW'(8) && slot < SW'(16);
  wire in_d  = live && (slot == SW'(16) || slot == SW'(17));
  wire last  = live && frm == FW'(FRAMES - 1) && slot == SW'(15);

  wire [2:0]    k    = slot[2:0];
  wire [FW-1:0] lane = FW'(FRAMES - 1) - frm;
  wire [FW+2:0] idx1 = {lane, mode[0] ? k : ~k};
  wire [FW+2:0] idx2 = {lane, mode[1] ? k : ~k};

  wire          swap  = bound && pend_full;
  wire [W-1:0]  act1_n = swap ? pend1 : act1;
  wire [W-1:0]  act2_n = swap ? pend2 : act2;

  always_comb begin
    sh1_n = sh1;
    sh2_n = sh2;
    if (in_b1) sh1_n[idx1] = rx_bit;
    if (in_b2) sh2_n[idx2] = rx_bit;
  end

  assign tx_bit = in_b1 ? act1_n[idx1] :
                  in_b2 ? act2_n[idx2] :
                  in_d  ? d_tx[slot[0]] : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      started     <= 1'b0;
      slot_q      <= '0;
      frm_q       <= '0;
      mode_q      <= '0;
      sh1         <= '0;
      sh2         <= '0;
      b1_rx_word  <= '0;
      b2_rx_word  <= '0;
      rx_valid    <= 1'b0;
      d_first     <= 1'b0;
      d_rx        <= '0;
      d_valid     <= 1'b0;
      act1        <= '0;
      act2        <= '0;
      pend1       <= '0;
      pend2       <= '0;
      pend_full   <= 1'b0;
      tx_underrun <= 1'b0;
    end else begin
      if (fsync) started <= 1'b1;
      slot_q   <= slot;
      frm_q    <= frm;
      mode_q   <= mode;
      sh1      <= sh1_n;
      sh2      <= sh2_n;
      rx_valid <= last;
      if (last) begin
        b1_rx_word <= sh1_n;
        b2_rx_word <= sh2_n;
      end
      if (live && slot == SW'(16)) d_first <= rx_bit;
      d_valid <= live && slot == SW'(17);
      if (live && slot == SW'(17)) d_rx <= {rx_bit, d_first};
      act1 <= act1_n;
      act2 <= act2_n;
      if (tx_load) begin
        pend1 <= b1_tx_word;
        pend2 <= b2_tx_word;
      end
      pend_full <= tx_load | (pend_full & ~bound);
      if (bound) tx_underrun <= ~pend_full;
    end
  end
endmodule

// File: rtl/bch_lw_packer_chk.sv
module bch_lw_packer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         fsync,
  input logic         started,
  input logic         tx_bit,
  input logic         rx_valid,
  input logic         d_valid,
  input logic         tx_underrun,
  input logic [1:0]   mode_q,
  input logic [W-1:0] b1_rx_word,
  input logic [W-1:0] b2_rx_word
);
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
  p_hold_b1_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(b1_rx_word) |-> rx_valid);
  p_hold_b2_r5: assert property (@(posedge clk) disable iff (rst)
    !$stable(b2_rx_word) |-> rx_valid);
  p_d_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    d_valid |=> !d_valid);
  p_idle_high_r10: assert property (@(posedge clk) disable iff (rst)
    (!started && !fsync) |-> tx_bit);
  p_underrun_at_bound_r9: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> $stable(tx_underrun));
  p_mode_latch_r11: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> $stable(mode_q));
endmodule

bind bch_lw_packer bch_lw_packer_chk #(.W(8 * FRAMES)) u_chk (
  .clk(clk), .rst(rst), .fsync(fsync), .started(started), .tx_bit(tx_bit),
  .rx_valid(rx_valid), .d_valid(d_valid), .tx_underrun(tx_underrun),
  .mode_q(mode_q), .b1_rx_word(b1_rx_word), .b2_rx_word(b2_rx_word)
);

// File: tb/test_bch_lw_packer.sv
`timescale 1ns/1ps
module test_bch_lw_packer;
  localparam int FB = 32;

  logic clk = 1'b0, rst = 1'b1, fsync = 1'b0, rx_bit = 1'b0;
  logic m1 = 1'b0, m2 = 1'b0, tx_load = 1'b0;
  logic [1:0] d_tx = '0;
  logic [31:0] b1_tx = '0, b2_tx = '0;
  logic tx_bit, rx_valid, d_valid, tx_underrun;
  logic [31:0] b1_rx, b2_rx;
  logic [1:0] d_rx;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  bch_lw_packer i_bch_lw_packer (
    .clk(clk), .rst(rst), .fsync(fsync), .rx_bit(rx_bit), .tx_bit(tx_bit),
    .mode_b1_hdlc(m1), .mode_b2_hdlc(m2), .b1_rx_word(b1_rx), .b2_rx_word(b2_rx),
    .rx_valid(rx_valid), .d_rx(d_rx), .d_valid(d_valid), .d_tx(d_tx),
    .tx_load(tx_load), .b1_tx_word(b1_tx), .b2_tx_word(b2_tx), .tx_underrun(tx_underrun)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic line_bit(input logic [31:0] w, input int f, input int s, input logic hd);
    logic [7:0] b = w[31 - 8*f -: 8];
    return hd ? b[s] : b[7 - s];
  endfunction

  // one four-frame group: rx words r1/r2 driven, tx words e1/e2 expected
  task automatic group(input int g, input logic hd1, input logic hd2,
                       input logic [31:0] r1, input logic [31:0] r2,
                       input logic [31:0] e1, input logic [31:0] e2, input logic eu,
                       input logic ld, input logic [31:0] l1, input logic [31:0] l2);
    for (int f = 0; f < 4; f++) begin
      logic [1:0] dv = 2'((f + g) & 3);
      for (int s = 0; s < FB; s++) begin
        logic exp;
        @(negedge clk);
        if (f == 0 && s == 1) chk(tx_underrun == eu, "R9 underrun", 32'(tx_underrun), 32'(eu));
        if (f == 3 && s == 16) begin
          chk(rx_valid == 1'b1, "R5 strobe", 32'(rx_valid), 1);
          chk(b1_rx == r1, hd1 ? "R3 R4 b1 rx word" : "R2 R4 b1 rx word", b1_rx, r1);
          chk(b2_rx == r2, hd2 ? "R3 R4 b2 rx word" : "R2 R4 b2 rx word", b2_rx, r2);
        end
        if (f == 3 && s == 17) chk(rx_valid == 1'b0, "R5 single pulse", 32'(rx_valid), 0);
        if (s == 18) begin
          chk(d_valid == 1'b1, "R6 d strobe", 32'(d_valid), 1);
          chk(d_rx == dv, "R6 d bits", 32'(d_rx), 32'(dv));
        end
        fsync   = (s == 0);
        tx_load = ld && f == 3 && s == 20;
        b1_tx   = l1;
        b2_tx   = l2;
        d_tx    = dv ^ 2'b01;
        if (f == 0 && s == 0) begin m1 = hd1; m2 = hd2; end
        if (f == 2 && s == 0) begin m1 = ~hd1; m2 = ~hd2; end  // R11 mid-group change
        if (s < 8)       rx_bit = line_bit(r1, f, s, hd1);
        else if (s < 16) rx_bit = line_bit(r2, f, s - 8, hd2);
        else if (s < 18) rx_bit = dv[s - 16];
        else             rx_bit = 1'b0;
        if (s < 8)       exp = line_bit(e1, f, s, hd1);
        else if (s < 16) exp = line_bit(e2, f, s - 8, hd2);
        else if (s < 18) exp = d_tx[s - 16];
        else             exp = 1'b1;
        #1;
        chk(tx_bit == exp, s < 16 ? "R1 R7 R8 R11 tx slot" : s < 18 ? "R6 d tx" : "R10 idle",
            32'(tx_bit), 32'(exp));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(b1_rx == 0 && b2_rx == 0, "R12 reset words", b1_rx, 0);
    chk(!rx_valid && !d_valid && !tx_underrun, "R12 reset flags",
        {rx_valid, d_valid, tx_underrun}, 0);
    #1 chk(tx_bit == 1'b1, "R10 idle before first fsync", 32'(tx_bit), 1);
    group(0, 0, 0, 32'h81C3_5A0F, 32'h1234_5678, 0, 0, 1, 1, 32'hA5F0_0F3C, 32'h8001_7E42);
    group(1, 0, 1, 32'hDEAD_BEEF, 32'h0180_C3E7, 32'hA5F0_0F3C, 32'h8001_7E42, 0,
          1, 32'h1F2E_3D4C, 32'hC001_5AA5);
    group(2, 1, 0, 32'h8040_2010, 32'hF00F_55AA, 32'h1F2E_3D4C, 32'hC001_5AA5, 0,
          0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    group(3, 1, 1, 32'h0102_0408, 32'h7E7E_8181, 32'h1F2E_3D4C, 32'hC001_5AA5, 1,
          1, 32'h9669_3CC3, 32'h0F1E_2D3C);
    group(4, 0, 0, 32'hCAFE_F00D, 32'h1357_9BDF, 32'h9669_3CC3, 32'h0F1E_2D3C, 0,
          0, 32'h0, 32'h0);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R5 no strobe in idle", 32'(rx_valid), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule